// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 52-bit physical address. It does so by reading a four-level radix page table from memory, one 64-bit entry at a time. A request carries the virtual address, a user/supervisor flag and a write flag. The block first checks that the address is canonical. It then reads one entry per level, starting from the table whose frame number sits on the root input. The walk can stop early on a large-page entry, giving a 2 MB or a 1 GB page. Permission bits are accumulated along the path. On the way, the walker writes the accessed and dirty bits back into memory.

The table layout is fixed. Each table holds 512 entries of 8 bytes. Each level is indexed by nine virtual-address bits, from bits 47..39 at the top down to bits 20..12 at the last level. The low 12 bits of the address are the page offset. A caller pulses start while the block is idle, watches busy, and takes the result or fault code in the cycle that done pulses. The result stays on the outputs until the next walk ends.

Top module: `ptw_walker`

## Requirements
- R1: An address whose bits 63..47 are not all equal finishes with fault code 1 (non-canonical) with done in the cycle after start. Busy stays low and no memory request is made. Both halves of the canonical space (bit 47 = 0 and bit 47 = 1) translate normally.
- R2: The top-level entry is read at {root_ppn, va[47:39], 3'b000}. Each lower level is read at {previous entry bits 51..12, next 9-bit index, 3'b000}, using va[38:30], then va[29:21], then va[20:12].
- R3: A fourth-level leaf gives res_pa = {entry[51:12], va[11:0]}, res_size = 0 and res_level = 3.
- R4: Bit 7 set in a second-level entry (level 1) ends the walk with a 1 GB page: res_size = 2 and res_pa = {entry[51:30], va[29:0]}. Bit 7 set in a third-level entry (level 2) ends it with a 2 MB page: res_size = 1 and res_pa = {entry[51:21], va[20:0]}. Bit 7 in a top-level entry is ignored.
- R5: An entry with bit 0 (present) clear ends the walk with fault code 2. res_level gives the level of that entry (0 is top, 3 is last). No further memory access follows.
- R6: On success, res_user is the AND of bit 2 (user) and res_write is the AND of bit 1 (writable) over every entry visited.
- R7: A user request with an effective user bit of 0 finishes with fault code 3. Otherwise, a write request with an effective writable bit of 0 finishes with fault code 4. Neither fault writes the leaf entry back.
- R8: Every present entry on the path of a walk that does not fault has bit 5 (accessed) set in memory. A successful write request also sets bit 6 (dirty) in the leaf. A write-back changes only those bits, and it is skipped when they are already set. On a permission fault, the entries above the leaf still get their accessed bit.
- R9: Start is taken only while idle. Busy is high from the cycle after a taken start until done. Done is a one-cycle pulse during which busy is low. A start pulse during a walk has no effect.
- R10: mem_req is high only while busy. It stays high until the cycle of mem_ack, and mem_we marks a write of mem_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| req_va | input | 64 | Virtual address to translate |
| req_user | input | 1 | 1 for a user-mode access |
| req_write | input | 1 | 1 for a write access |
| root_ppn | input | 40 | Frame number of the top-level table |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 when the request is a write |
| mem_addr | output | 52 | Byte address of the 64-bit entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| res_fault | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 user, 4 write |
| res_level | output | 2 | Level of the final or faulting entry |
| res_pa | output | 52 | Translated physical address (0 on fault) |
| res_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| res_user | output | 1 | Effective user permission |
| res_write | output | 1 | Effective write permission |

## Verification
The bench uses a large-page entry whose frame number has nonzero low bits. A walker that forgot to mask them would corrupt the translated address. It also puts bit 7 on a top-level entry, which a careless leaf test would treat as a 512 GB page. Permission faults are driven by an upper-level entry that clears the user or writable bit while the leaf allows the access. This catches a walker that checks only the leaf, and a case with both bits clear checks that the user fault wins. Write-back counts and the entry values in memory expose a walker that rewrites entries whose accessed and dirty bits are already set, or that marks the leaf after a fault. Non-canonical addresses in both halves, a missing entry at the top and in the middle, and a second start during a walk round out the set.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int EB_P  = 0;
  localparam int EB_W  = 1;
  localparam int EB_U  = 2;
  localparam int EB_A  = 5;
  localparam int EB_D  = 6;
  localparam int EB_PS = 7;

  localparam logic [2:0] FLT_NONE     = 3'd0;
  localparam logic [2:0] FLT_NONCANON = 3'd1;
  localparam logic [2:0] FLT_ABSENT   = 3'd2;
  localparam logic [2:0] FLT_USER     = 3'd3;
  localparam logic [2:0] FLT_WRITE    = 3'd4;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ISSUE = 2'd1,
    WS_READ  = 2'd2,
    WS_WBACK = 2'd3
  } walk_st_e;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 48
) (
  input  logic [ADDR_W-1:0] va,
  output logic              ok
);
  localparam int HI_W = ADDR_W - VA_W + 1;
  logic [HI_W-1:0] hi;
  assign hi = va[ADDR_W-1:VA_W-1];
  assign ok = (&hi) | ~(|hi);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int LEVELS   = 4,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int ENT_B   = PG_SHIFT - IDX_W
) (
  input  logic [PPN_W-1:0] table_ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  ent_addr
);
  logic [IDX_W-1:0] idx_lv [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_lv[l] = va[PG_SHIFT + IDX_W*(LEVELS-1-l) +: IDX_W];
  end

  assign ent_addr = {table_ppn, idx_lv[level], {ENT_B{1'b0}}};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int PA_W     = 52,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int LEVELS   = 4,
  parameter int ENT_W    = 64,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int OFF_W   = PG_SHIFT + IDX_W*(LEVELS-2)
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] level,
  input  logic             acc_u,
  input  logic             acc_w,
  input  logic             req_user,
  input  logic             req_write,
  input  logic [OFF_W-1:0] va_off,
  output logic             leaf,
  output logic [2:0]       fault,
  output logic             nxt_u,
  output logic             nxt_w,
  output logic             wb_need,
  output logic [ENT_W-1:0] wb_data,
  output logic [PPN_W-1:0] nxt_ppn,
  output logic [PA_W-1:0]  page_pa,
  output logic [1:0]       page_size
);
  logic [PA_W-1:0] base_pa;
  logic [PA_W-1:0] off_ext;
  logic [PA_W-1:0] pa_lv [LEVELS];

  assign nxt_ppn = entry[PA_W-1:PG_SHIFT];
  assign base_pa = {nxt_ppn, {PG_SHIFT{1'b0}}};
  assign off_ext = {{(PA_W-OFF_W){1'b0}}, va_off};

  for (genvar l = 0; l < LEVELS; l++) begin : g_pa
    localparam int OB = PG_SHIFT + IDX_W*(LEVELS-1-l);
    localparam logic [PA_W-1:0] MSK = PA_W'((64'd1 << OB) - 64'd1);
    assign pa_lv[l] = (base_pa & ~MSK) | (off_ext & MSK);
  end

  assign nxt_u     = acc_u & entry[EB_U];
  assign nxt_w     = acc_w & entry[EB_W];
  assign leaf      = (int'(level) == LEVELS-1) || (entry[EB_PS] && (level != '0));
  assign page_pa   = pa_lv[level];
  assign page_size = 2'(LEVELS - 1 - int'(level));

  always_comb begin
    if (!entry[EB_P])                 fault = FLT_ABSENT;
    else if (leaf && req_user && !nxt_u)  fault = FLT_USER;
    else if (leaf && req_write && !nxt_w) fault = FLT_WRITE;
    else                              fault = FLT_NONE;
  end

  always_comb begin
    wb_data = entry;
    wb_data[EB_A] = 1'b1;
    if (leaf && req_write) wb_data[EB_D] = 1'b1;
  end

  assign wb_need = (fault == FLT_NONE) && (wb_data != entry);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int LEVELS   = 4,
  parameter int ENT_W    = 64,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int OFF_W   = PG_SHIFT + IDX_W*(LEVELS-2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_va,
  input  logic              req_user,
  input  logic              req_write,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        res_fault,
  output logic [LVL_W-1:0]  res_level,
  output logic [PA_W-1:0]   res_pa,
  output logic [1:0]        res_size,
  output logic              res_user,
  output logic              res_write
);
  walk_st_e         st;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] tbl_ppn;
  logic [VA_W-1:0]  va_q;
  logic             user_q, write_q;
  logic             acc_u, acc_w;
  logic             leaf_q;
  logic [PA_W-1:0]  pend_pa;
  logic [1:0]       pend_size;
  logic [ENT_W-1:0] rd_entry_q;

  logic             canon_ok;
  logic [PA_W-1:0]  agen_addr;
  logic             ev_leaf, ev_u, ev_w, ev_wb;
  logic [2:0]       ev_fault;
  logic [ENT_W-1:0] ev_wdata;
  logic [PPN_W-1:0] ev_ppn;
  logic [PA_W-1:0]  ev_pa;
  logic [1:0]       ev_size;

  ptw_canon #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_canon (
    .va(req_va), .ok(canon_ok)
  );

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
                 .IDX_W(IDX_W), .LEVELS(LEVELS)) u_agen (
    .table_ppn(tbl_ppn), .va(va_q), .level(lvl), .ent_addr(agen_addr)
  );

  ptw_entry_eval #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
                   .LEVELS(LEVELS), .ENT_W(ENT_W)) u_eval (
    .entry(mem_rdata), .level(lvl), .acc_u(acc_u), .acc_w(acc_w),
    .req_user(user_q), .req_write(write_q), .va_off(va_q[OFF_W-1:0]),
    .leaf(ev_leaf), .fault(ev_fault), .nxt_u(ev_u), .nxt_w(ev_w),
    .wb_need(ev_wb), .wb_data(ev_wdata), .nxt_ppn(ev_ppn),
    .page_pa(ev_pa), .page_size(ev_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WS_IDLE;
      lvl        <= '0;
      tbl_ppn    <= '0;
      va_q       <= '0;
      user_q     <= 1'b0;
      write_q    <= 1'b0;
      acc_u      <= 1'b0;
      acc_w      <= 1'b0;
      leaf_q     <= 1'b0;
      pend_pa    <= '0;
      pend_size  <= '0;
      rd_entry_q <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      res_fault  <= FLT_NONE;
      res_level  <= '0;
      res_pa     <= '0;
      res_size   <= '0;
      res_user   <= 1'b0;
      res_write  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        WS_IDLE: begin
          if (start) begin
            va_q    <= req_va[VA_W-1:0];
            user_q  <= req_user;
            write_q <= req_write;
            tbl_ppn <= root_ppn;
            lvl     <= '0;
            acc_u   <= 1'b1;
            acc_w   <= 1'b1;
            if (!canon_ok) begin
              done      <= 1'b1;
              res_fault <= FLT_NONCANON;
              res_level <= '0;
              res_pa    <= '0;
              res_size  <= '0;
              res_user  <= 1'b0;
              res_write <= 1'b0;
            end else begin
              busy <= 1'b1;
              st   <= WS_ISSUE;
            end
          end
        end
        WS_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= agen_addr;
          st       <= WS_READ;
        end
        WS_READ: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            rd_entry_q <= mem_rdata;
            acc_u      <= ev_u;
            acc_w      <= ev_w;
            tbl_ppn    <= ev_ppn;
            leaf_q     <= ev_leaf;
            pend_pa    <= ev_pa;
            pend_size  <= ev_size;
            if (ev_fault != FLT_NONE) begin
              busy      <= 1'b0;
              done      <= 1'b1;
              res_fault <= ev_fault;
              res_level <= lvl;
              res_pa    <= '0;
              res_size  <= '0;
              res_user  <= 1'b0;
              res_write <= 1'b0;
              st        <= WS_IDLE;
            end else if (ev_wb) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= ev_wdata;
              st        <= WS_WBACK;
            end else if (ev_leaf) begin
              busy      <= 1'b0;
              done      <= 1'b1;
              res_fault <= FLT_NONE;
              res_level <= lvl;
              res_pa    <= ev_pa;
              res_size  <= ev_size;
              res_user  <= ev_u;
              res_write <= ev_w;
              st        <= WS_IDLE;
            end else begin
              lvl <= lvl + LVL_W'(1);
              st  <= WS_ISSUE;
            end
          end
        end
        WS_WBACK: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (leaf_q) begin
              busy      <= 1'b0;
              done      <= 1'b1;
              res_fault <= FLT_NONE;
              res_level <= lvl;
              res_pa    <= pend_pa;
              res_size  <= pend_size;
              res_user  <= acc_u;
              res_write <= acc_w;
              st        <= WS_IDLE;
            end else begin
              lvl <= lvl + LVL_W'(1);
              st  <= WS_ISSUE;
            end
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  localparam logic [ENT_W-1:0] AD_MSK = (ENT_W'(1) << EB_A) | (ENT_W'(1) << EB_D);

  AST_NONCANON_EARLY: assert property (@(posedge clk) disable iff (rst)
    (st == WS_IDLE && start && !canon_ok) |=> (done && !busy && res_fault == FLT_NONCANON)); // R1
  AST_WB_ONLY_AD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (((mem_wdata | AD_MSK) == (rd_entry_q | AD_MSK)) && mem_wdata[EB_A])); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_REQ_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_USER_OK: assert property (@(posedge clk) disable iff (rst)
    (done && res_fault == FLT_NONE && user_q) |-> res_user); // R7
  AST_WRITE_OK: assert property (@(posedge clk) disable iff (rst)
    (done && res_fault == FLT_NONE && write_q) |-> res_write); // R7
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_user = 1'b0, req_write = 1'b0;
  logic [39:0] root_ppn = 40'h100;
  logic        mem_req, mem_we;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy, done;
  logic [2:0]  res_fault;
  logic [1:0]  res_level;
  logic [51:0] res_pa;
  logic [1:0]  res_size;
  logic        res_user, res_write;

  int checks = 0, errors = 0;
  int nrd = 0, nwr = 0;
  logic [63:0] pmem [logic [51:0]];

  localparam logic [11:0] P = 12'h001, W = 12'h002, U = 12'h004;
  localparam logic [11:0] A = 12'h020, D = 12'h040, PS = 12'h080;

  always #10 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst(rst), .start(start), .req_va(req_va),
    .req_user(req_user), .req_write(req_write), .root_ppn(root_ppn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .res_fault(res_fault), .res_level(res_level),
    .res_pa(res_pa), .res_size(res_size), .res_user(res_user),
    .res_write(res_write)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          pmem[mem_addr] = mem_wdata;
          nwr++;
        end else begin
          mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 64'h0;
          nrd++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pte(input logic [39:0] ppn, input logic [11:0] fl);
    return {12'h0, ppn, fl};
  endfunction

  function automatic logic [51:0] eaddr(input logic [39:0] tp, input logic [63:0] va, input int l);
    return {tp, va[(39 - 9*l) +: 9], 3'b000};
  endfunction

  task automatic put(input logic [39:0] tp, input logic [63:0] va, input int l, input logic [63:0] e);
    pmem[eaddr(tp, va, l)] = e;
  endtask

  function automatic logic [63:0] peek(input logic [39:0] tp, input logic [63:0] va, input int l);
    return pmem[eaddr(tp, va, l)];
  endfunction

  task automatic walk(input logic [63:0] va, input bit u, input bit w, input bit poke, input bit canon);
    int n;
    nrd = 0; nwr = 0;
    @(negedge clk);
    req_va = va; req_user = u; req_write = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (canon) chk(busy === 1'b1, "R9 busy after start", 64'(busy), 64'd1);
    else       chk(busy === 1'b0, "R1 busy stays low", 64'(busy), 64'd0);
    n = 0;
    while (done !== 1'b1 && n < 400) begin
      if (poke && n == 2) begin
        req_va = 64'h0001_0000_0000_0000; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R9 done seen", 64'(done), 64'd1);
    chk(busy === 1'b0, "R9 idle with done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    chk(mem_req === 1'b0, "R10 no request after done", 64'(mem_req), 64'd0);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0, "R9 reset idle", {62'd0, busy, done}, 64'd0);
    chk(mem_req === 1'b0, "R10 reset no request", 64'(mem_req), 64'd0);
  endtask

  task automatic t_4k_user_read;
    logic [63:0] va = 64'h0000_1234_5678_9ABC;
    put(40'h100, va, 0, pte(40'h201, P|U|W));
    put(40'h201, va, 1, pte(40'h202, P|U|W|PS & 12'h0));
    put(40'h202, va, 2, pte(40'h203, P|U|W));
    put(40'h203, va, 3, pte(40'hABCDE, P|U|W));
    walk(va, 1, 0, 0, 1);
    chk(res_fault == 3'd0, "R3 fault", 64'(res_fault), 64'd0);
    chk(res_pa == {40'hABCDE, 12'hABC}, "R2 R3 4K address", 64'(res_pa), 64'({40'hABCDE, 12'hABC}));
    chk(res_size == 2'd0 && res_level == 2'd3, "R3 size/level", {60'd0, res_size, res_level}, 64'h3);
    chk(res_user && res_write, "R6 perms all set", {62'd0, res_user, res_write}, 64'h3);
    chk(nrd == 4 && nwr == 4, "R8 A written on each level", 64'(nwr), 64'd4);
    chk(peek(40'h100, va, 0) == pte(40'h201, P|U|W|A), "R8 top A set", peek(40'h100, va, 0), pte(40'h201, P|U|W|A));
    chk(peek(40'h203, va, 3) == pte(40'hABCDE, P|U|W|A), "R8 read leaf no D", peek(40'h203, va, 3), pte(40'hABCDE, P|U|W|A));
  endtask

  task automatic t_4k_write_poke;
    logic [63:0] va = 64'h0000_7F80_1234_5000;
    put(40'h100, va, 0, pte(40'h211, P|U|W|A));
    put(40'h211, va, 1, pte(40'h212, P|U|W|A));
    put(40'h212, va, 2, pte(40'h213, P|U|W|A));
    put(40'h213, va, 3, pte(40'h0_5555_5, P|U|W|A));
    walk(va, 0, 1, 1, 1);
    chk(res_fault == 3'd0, "R9 second start ignored", 64'(res_fault), 64'd0);
    chk(res_pa == {40'h0_5555_5, 12'h000}, "R3 write address", 64'(res_pa), 64'({40'h0_5555_5, 12'h0}));
    chk(nwr == 1, "R8 only leaf written", 64'(nwr), 64'd1);
    chk(peek(40'h213, va, 3) == pte(40'h0_5555_5, P|U|W|A|D), "R8 dirty set", peek(40'h213, va, 3), pte(40'h0_5555_5, P|U|W|A|D));
  endtask

  task automatic t_2m;
    logic [63:0] va = 64'h0000_0100_4060_1234;
    logic [51:0] exp;
    put(40'h100, va, 0, pte(40'h301, P|U|W));
    put(40'h301, va, 1, pte(40'h302, P|U|W));
    put(40'h302, va, 2, pte(40'h4A5FF, P|U|PS));
    exp = {40'h4A5FF >> 9, va[20:0]};
    walk(va, 1, 0, 0, 1);
    chk(res_fault == 3'd0 && res_size == 2'd1, "R4 2M size", 64'(res_size), 64'd1);
    chk(res_pa == exp, "R4 2M address masks low frame bits", 64'(res_pa), 64'(exp));
    chk(res_level == 2'd2 && nrd == 3, "R4 stops at third level", 64'(nrd), 64'd3);
    chk(res_user && !res_write, "R6 leaf W=0 reported", {62'd0, res_user, res_write}, 64'h2);
  endtask

  task automatic t_1g;
    logic [63:0] va = 64'h0000_0300_8765_4321;
    logic [51:0] exp;
    put(40'h100, va, 0, pte(40'h401, P|W|U|PS|A));
    put(40'h401, va, 1, pte(40'h12_3456_789, P|W|PS));
    exp = {40'h12_3456_789 >> 18, va[29:0]};
    walk(va, 0, 0, 0, 1);
    chk(res_fault == 3'd0 && res_size == 2'd2, "R4 1G size, top PS ignored", 64'(res_size), 64'd2);
    chk(res_pa == exp, "R4 1G address", 64'(res_pa), 64'(exp));
    chk(!res_user && res_write, "R6 U cleared at leaf", {62'd0, res_user, res_write}, 64'h1);
    chk(nrd == 2 && nwr == 1, "R8 A only on second level", 64'(nwr), 64'd1);
  endtask

  task automatic t_high_half_no_wb;
    logic [63:0] va = 64'hFFFF_8000_0000_5123;
    put(40'h100, va, 0, pte(40'h501, P|U|W|A));
    put(40'h501, va, 1, pte(40'h502, P|U|W|A));
    put(40'h502, va, 2, pte(40'h503, P|U|W|A));
    put(40'h503, va, 3, pte(40'hFF_FFFF_FFFF, P|U|W|A|D));
    walk(va, 0, 1, 0, 1);
    chk(res_fault == 3'd0, "R1 high canonical half", 64'(res_fault), 64'd0);
    chk(res_pa == {40'hFF_FFFF_FFFF, 12'h123}, "R3 top frame", 64'(res_pa), 64'({40'hFF_FFFF_FFFF, 12'h123}));
    chk(nwr == 0, "R8 no write when A and D set", 64'(nwr), 64'd0);
  endtask

  task automatic t_noncanon;
    walk(64'h0001_0000_0000_0000, 0, 0, 0, 0);
    chk(res_fault == 3'd1 && nrd == 0 && nwr == 0, "R1 low-half bit48", 64'(res_fault), 64'd1);
    walk(64'hFFFF_0000_0000_0000, 0, 0, 0, 0);
    chk(res_fault == 3'd1 && nrd == 0, "R1 high bits with bit47 clear", 64'(res_fault), 64'd1);
  endtask

  task automatic t_absent;
    logic [63:0] va = 64'h0000_0400_0000_7000;
    put(40'h100, va, 0, pte(40'h601, P|U|W));
    put(40'h601, va, 1, pte(40'h602, P|U|W));
    walk(va, 0, 0, 0, 1);
    chk(res_fault == 3'd2 && res_level == 2'd2, "R5 absent at level 2", {59'd0, res_fault, res_level}, 64'h0A);
    chk(nrd == 3 && nwr == 2, "R5 no access past absent entry", 64'(nrd), 64'd3);
    chk(res_pa == 52'd0, "R5 address zero on fault", 64'(res_pa), 64'd0);
    walk(64'h0000_0480_0000_0000, 0, 0, 0, 1);
    chk(res_fault == 3'd2 && res_level == 2'd0 && nrd == 1, "R5 absent at top", {59'd0, res_fault, res_level}, 64'h08);
  endtask

  task automatic t_perm;
    logic [63:0] va = 64'h0000_0500_0000_1000;
    put(40'h100, va, 0, pte(40'h701, P|W|A));
    put(40'h701, va, 1, pte(40'h702, P|U|W|A));
    put(40'h702, va, 2, pte(40'h703, P|U|W|A));
    put(40'h703, va, 3, pte(40'h777, P|U|W));
    walk(va, 1, 0, 0, 1);
    chk(res_fault == 3'd3 && res_level == 2'd3, "R7 user blocked by top U=0", 64'(res_fault), 64'd3);
    chk(nwr == 0 && peek(40'h703, va, 3) == pte(40'h777, P|U|W), "R7 leaf untouched", peek(40'h703, va, 3), pte(40'h777, P|U|W));
    va = 64'h0000_0580_0000_2000;
    put(40'h100, va, 0, pte(40'h801, P|U|W|A));
    put(40'h801, va, 1, pte(40'h802, P|U|A));
    put(40'h802, va, 2, pte(40'h803, P|U|W|A));
    put(40'h803, va, 3, pte(40'h888, P|U|W|A));
    walk(va, 1, 1, 0, 1);
    chk(res_fault == 3'd4, "R7 write blocked by mid W=0", 64'(res_fault), 64'd4);
    va = 64'h0000_0600_0000_0000;
    put(40'h100, va, 0, pte(40'h901, P|A));
    put(40'h901, va, 1, pte(40'h902, P|A));
    put(40'h902, va, 2, pte(40'h903, P|A));
    put(40'h903, va, 3, pte(40'h999, P|A));
    walk(va, 1, 1, 0, 1);
    chk(res_fault == 3'd3, "R7 user fault before write fault", 64'(res_fault), 64'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_4k_user_read();
    t_4k_write_poke();
    t_2m();
    t_1g();
    t_high_half_no_wb();
    t_noncanon();
    t_absent();
    t_perm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule